// File: doc/BRIEF.md
# Parallel Port Host Register Interface

This block sits between a host I/O bus and the pins of a legacy printer-style parallel port. The host reaches three byte-wide registers through a two-bit address and active-low read and write strobes: a data register, a status register and a control register. Writes land on the rising (trailing) edge of the write strobe. The control register drives four peripheral control lines. Some of these lines are inverted and some are not, and each is read back from its pad, not from the stored bit. The status register reports the peripheral's status pins through synchronizers. It is frozen for as long as a read strobe is held.

A three-bit mode input selects one of three modes. In standard output mode the data lines are always driven. In bidirectional mode a control bit can turn the data drivers off. In enhanced mode, a data-register access starts a transfer cycle. That cycle must see the peripheral's handshake (the busy pin high) within a parameterized number of clock cycles. If it does not, the cycle is aborted and a sticky timeout flag appears in status bit 0. The host clears the flag by writing a one to that bit, and leaving enhanced mode also clears it. A level interrupt is asserted while the acknowledge interrupt enable is set and the ack pin is low.

Top module: `ppt_host_regs`

## Requirements
- R1: Register addresses are 0 for data, 1 for status and 2 for control. A write to address 0 is captured on the rising edge of `host_wr_n_i` and appears on `pd_out_o`. A read of address 0 returns the synchronized level of `pd_in_i`.
- R2: Control bits 0, 1 and 3 drive `stb_n_o`, `afd_n_o` and `selin_n_o` inverted. Read bits 0, 1 and 3 of the control register return the complement of the synchronized pad inputs `stb_pad_i`, `afd_pad_i` and `selin_pad_i`.
- R3: Control bit 2 drives `init_n_o` without inversion. Read bit 2 returns the synchronized `init_pad_i` level unchanged.
- R4: Control bit 5 selects the data direction: 0 is output and 1 is input. `pd_oe_o` is 0 only when bit 5 is 1 and the mode is not standard (`mode_i` = 000). In standard mode the data lines are always driven.
- R5: `irq_o` is a level equal to control bit 4 AND NOT the synchronized `ack_n_i`. It follows both inputs and is never pulsed.
- R6: While `host_rd_n_i` is held low, the status read value stays at the value sampled before the strobe fell, even if the pins change.
- R7: Status read bits 2:1 are always 11. Bit 3 is `err_n_i`, bit 4 is `sel_i`, bit 5 is `pe_i` and bit 6 is `ack_n_i`, all at their true levels. Bit 7 is the complement of `busy_i`.
- R8: Status bit 0 reads 1 unless `mode_i` = 100 (enhanced). In enhanced mode, a falling edge of either strobe at address 0 starts a cycle. If the synchronized `busy_i` is not high within TIMEOUT_CYC clock cycles, the cycle is aborted and bit 0 becomes a sticky 1. A handshake in time leaves it 0.
- R9: The timeout flag is cleared by a status write with data bit 0 = 1, or by any cycle in which the mode is not enhanced. A status write with bit 0 = 0 leaves the flag unchanged.
- R10: Control read bits 7:6 always return 11. After reset all writable control bits are 0, so the outputs are `stb_n_o`=1, `afd_n_o`=1, `init_n_o`=0, `selin_n_o`=1, `pd_oe_o`=1 and `irq_o`=0, and the timeout flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Port mode: 000 standard, 001 bidirectional, 100 enhanced |
| host_addr_i | input | 2 | Register address |
| host_wr_n_i | input | 1 | Host write strobe, active low |
| host_rd_n_i | input | 1 | Host read strobe, active low |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data |
| irq_o | output | 1 | Acknowledge interrupt level |
| pd_out_o | output | 8 | Data lines output value |
| pd_oe_o | output | 1 | Data line driver enable |
| pd_in_i | input | 8 | Data lines input value |
| stb_n_o | output | 1 | Strobe pin drive |
| afd_n_o | output | 1 | Autofeed pin drive |
| init_n_o | output | 1 | Init pin drive |
| selin_n_o | output | 1 | Select-in pin drive |
| stb_pad_i | input | 1 | Strobe pad level |
| afd_pad_i | input | 1 | Autofeed pad level |
| init_pad_i | input | 1 | Init pad level |
| selin_pad_i | input | 1 | Select-in pad level |
| err_n_i | input | 1 | Error pin |
| sel_i | input | 1 | Select pin |
| pe_i | input | 1 | Paper-end pin |
| ack_n_i | input | 1 | Acknowledge pin |
| busy_i | input | 1 | Busy pin, also the enhanced handshake |

## Verification
The results of a register write reach the pins one clock after the rising edge of the write strobe. A value that comes back through a pad or a status pin passes through two synchronizer flops. The status snapshot then adds one more clock. An enhanced cycle that gets no handshake sets the flag TIMEOUT_CYC clocks after its start edge. For each access the bench waits at least four clocks, and it samples at falling clock edges. Timeout probes are placed well before and well after the limit, so no check lands near a boundary cycle.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
   localparam int unsigned BYTE_W = 8;

   localparam logic [2:0] MODE_STD   = 3'b000;
   localparam logic [2:0] MODE_BIDIR = 3'b001;
   localparam logic [2:0] MODE_ENH   = 3'b100;

   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_CTRL = 2'd2;

   localparam int unsigned CB_STB   = 0;
   localparam int unsigned CB_AFD   = 1;
   localparam int unsigned CB_INIT  = 2;
   localparam int unsigned CB_SELIN = 3;
   localparam int unsigned CB_IE    = 4;
   localparam int unsigned CB_DIR   = 5;
   localparam int unsigned CTL_W    = 6;

   typedef struct packed {
      logic [BYTE_W-1:0] pdata;
      logic              selin;
      logic              init;
      logic              afd;
      logic              stb;
      logic              busy;
      logic              ack_n;
      logic              pe;
      logic              sel;
      logic              err_n;
   } ppt_pins_t;

   localparam int unsigned PINS_W = $bits(ppt_pins_t);
endpackage

// File: rtl/ppt_sync.sv
module ppt_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ppt_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ppt_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ppt_timeout.sv
module ppt_timeout #(
   parameter int unsigned TIMEOUT_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic done_i,
   input  logic clr_i,
   input  logic leave_i,
   output logic flag_o
);
   localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_limit
         $error("ppt_timeout: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic          active_q;
   logic [CW-1:0] cnt_q;
   logic          flag_q;
   logic          hit;

   assign hit = active_q & ~start_i & ~done_i & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         flag_q   <= 1'b0;
      end else if (leave_i) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         flag_q   <= 1'b0;
      end else begin
         if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
         end else if (active_q) begin
            if (done_i || hit) begin
               active_q <= 1'b0;
               cnt_q    <= '0;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
         flag_q <= hit | (flag_q & ~clr_i);
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/ppt_host_regs.sv
module ppt_host_regs
   import ppt_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned TIMEOUT_CYC  = 64,
   parameter bit          PAD_READBACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic [1:0]        host_addr_i,
   input  logic              host_wr_n_i,
   input  logic              host_rd_n_i,
   input  logic [BYTE_W-1:0] host_wdata_i,
   output logic [BYTE_W-1:0] host_rdata_o,
   output logic              irq_o,
   output logic [BYTE_W-1:0] pd_out_o,
   output logic              pd_oe_o,
   input  logic [BYTE_W-1:0] pd_in_i,
   output logic              stb_n_o,
   output logic              afd_n_o,
   output logic              init_n_o,
   output logic              selin_n_o,
   input  logic              stb_pad_i,
   input  logic              afd_pad_i,
   input  logic              init_pad_i,
   input  logic              selin_pad_i,
   input  logic              err_n_i,
   input  logic              sel_i,
   input  logic              pe_i,
   input  logic              ack_n_i,
   input  logic              busy_i
);
   logic              wr_q, rd_q;
   logic              wr_done, wr_start, rd_start;
   logic [BYTE_W-1:0] data_q;
   logic [CTL_W-1:0]  ctl_q;
   logic              is_enh;
   logic              to_flag;
   logic              ack_ie;
   logic [BYTE_W-1:0] stat_live, stat_snap, ctl_rd;
   logic [3:0]        ctl_low;
   ppt_pins_t         raw, syn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b1;
         rd_q <= 1'b1;
      end else begin
         wr_q <= host_wr_n_i;
         rd_q <= host_rd_n_i;
      end
   end

   assign wr_done  = ~wr_q & host_wr_n_i;
   assign wr_start = wr_q & ~host_wr_n_i;
   assign rd_start = rd_q & ~host_rd_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ctl_q  <= '0;
      end else if (wr_done) begin
         if (host_addr_i == ADDR_DATA) data_q <= host_wdata_i;
         if (host_addr_i == ADDR_CTRL) ctl_q  <= host_wdata_i[CTL_W-1:0];
      end
   end

   assign stb_n_o   = ~ctl_q[CB_STB];
   assign afd_n_o   = ~ctl_q[CB_AFD];
   assign init_n_o  =  ctl_q[CB_INIT];
   assign selin_n_o = ~ctl_q[CB_SELIN];
   assign pd_out_o  = data_q;
   assign pd_oe_o   = (mode_i == MODE_STD) | ~ctl_q[CB_DIR];
   assign ack_ie    = ctl_q[CB_IE];

   assign raw = '{pdata: pd_in_i, selin: selin_pad_i, init: init_pad_i,
                  afd: afd_pad_i, stb: stb_pad_i, busy: busy_i,
                  ack_n: ack_n_i, pe: pe_i, sel: sel_i, err_n: err_n_i};

   ppt_sync #(.WIDTH(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (raw),
      .q_o  (syn)
   );

   assign is_enh = (mode_i == MODE_ENH);

   ppt_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_to (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(is_enh & (wr_start | rd_start) & (host_addr_i == ADDR_DATA)),
      .done_i (syn.busy),
      .clr_i  (wr_done & (host_addr_i == ADDR_STAT) & host_wdata_i[0]),
      .leave_i(~is_enh),
      .flag_o (to_flag)
   );

   assign stat_live = {~syn.busy, syn.ack_n, syn.pe, syn.sel, syn.err_n,
                       2'b11, (is_enh ? to_flag : 1'b1)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           stat_snap <= '1;
      else if (host_rd_n_i) stat_snap <= stat_live;
   end

   generate
      if (PAD_READBACK) begin : g_pad_rb
         assign ctl_low = {~syn.selin, syn.init, ~syn.afd, ~syn.stb};
      end else begin : g_reg_rb
         assign ctl_low = ctl_q[3:0];
      end
   endgenerate

   assign ctl_rd = {2'b11, ctl_q[CB_DIR], ctl_q[CB_IE], ctl_low};

   always_comb begin
      case (host_addr_i)
         ADDR_DATA: host_rdata_o = syn.pdata;
         ADDR_STAT: host_rdata_o = stat_snap;
         ADDR_CTRL: host_rdata_o = ctl_rd;
         default:   host_rdata_o = '1;
      endcase
   end

   assign irq_o = ack_ie & ~syn.ack_n;
endmodule

// File: rtl/ppt_host_regs_chk.sv
module ppt_host_regs_chk
   import ppt_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode_i,
   input logic [1:0]        host_addr_i,
   input logic              host_wr_n_i,
   input logic              host_rd_n_i,
   input logic              wdata0_i,
   input logic [1:0]        rd_hi_i,
   input logic [1:0]        rd_fix_i,
   input logic              irq_o,
   input logic              pd_oe_o,
   input logic              stb_n_o,
   input logic              ie_i,
   input logic [BYTE_W-1:0] snap_i,
   input logic              flag_i
);
   assert_strobe_inverted_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_n_i && !$past(host_wr_n_i) && host_addr_i == ADDR_CTRL)
      |=> (stb_n_o == ~$past(wdata0_i)));

   assert_std_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_STD) |-> pd_oe_o);

   assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_i |-> !irq_o);

   assert_status_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rd_n_i && !$past(host_rd_n_i)) |-> $stable(snap_i));

   assert_status_fixed_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr_i == ADDR_STAT) |-> (rd_fix_i == 2'b11));

   assert_flag_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != MODE_ENH && $past(mode_i) != MODE_ENH) |-> !flag_i);

   assert_ctl_high_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr_i == ADDR_CTRL) |-> (rd_hi_i == 2'b11));
endmodule

bind ppt_host_regs ppt_host_regs_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_i     (mode_i),
   .host_addr_i(host_addr_i),
   .host_wr_n_i(host_wr_n_i),
   .host_rd_n_i(host_rd_n_i),
   .wdata0_i   (host_wdata_i[0]),
   .rd_hi_i    (host_rdata_o[7:6]),
   .rd_fix_i   (host_rdata_o[2:1]),
   .irq_o      (irq_o),
   .pd_oe_o    (pd_oe_o),
   .stb_n_o    (stb_n_o),
   .ie_i       (ack_ie),
   .snap_i     (stat_snap),
   .flag_i     (to_flag)
);

// File: tb/ppt_host_regs_bench.sv
module ppt_host_regs_bench;
   localparam int unsigned TO_CYC = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode = 3'b000;
   logic [1:0] addr = 2'd0;
   logic       wr_n = 1'b1, rd_n = 1'b1;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq, pd_oe;
   logic [7:0] pd_out;
   logic [7:0] pd_in = 8'h00;
   logic       stb_n, afd_n, init_n, selin_n;
   logic [3:0] flip = 4'h0;
   logic       err_n = 1'b1, sel = 1'b0, pe = 1'b0, ack_n = 1'b1, busy = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ppt_host_regs #(.TIMEOUT_CYC(TO_CYC)) u_ppt_host_regs (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .host_addr_i(addr),
      .host_wr_n_i(wr_n), .host_rd_n_i(rd_n), .host_wdata_i(wdata),
      .host_rdata_o(rdata), .irq_o(irq), .pd_out_o(pd_out), .pd_oe_o(pd_oe),
      .pd_in_i(pd_in), .stb_n_o(stb_n), .afd_n_o(afd_n), .init_n_o(init_n),
      .selin_n_o(selin_n),
      .stb_pad_i(stb_n ^ flip[0]), .afd_pad_i(afd_n ^ flip[1]),
      .init_pad_i(init_n ^ flip[2]), .selin_pad_i(selin_n ^ flip[3]),
      .err_n_i(err_n), .sel_i(sel), .pe_i(pe), .ack_n_i(ack_n), .busy_i(busy)
   );

   function automatic logic [7:0] exp_status(logic bit0);
      return {~busy, ack_n, pe, sel, err_n, 2'b11, bit0};
   endfunction

   function automatic logic [7:0] exp_ctrl(logic [5:0] c);
      return {2'b11, c[5], c[4], c[3:0] ^ flip};
   endfunction

   function automatic logic [3:0] exp_pins(logic [5:0] c);
      return {~c[3], c[2], ~c[1], ~c[0]};
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_n = 1'b0;
      wait_cyc(2);
      wr_n = 1'b1;
      wait_cyc(4);
   endtask

   task automatic host_read(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_n = 1'b0;
      @(negedge clk);
      d = rdata;
      rd_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
         $finish;
      end
   end

   initial begin
      logic [7:0] r, v1;
      logic [5:0] c;
      void'($urandom(32'h00C0FFEE));
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(4);

      // R10 reset state
      check("R10 reset pins", {4'h0, selin_n, init_n, afd_n, stb_n}, 8'h0B);
      check("R10 reset oe/irq", {6'h0, pd_oe, irq}, 8'h02);
      host_read(2'd2, r);
      check("R10 reset ctrl read", r, 8'hC0);
      host_read(2'd1, r);
      check("R7 status std", r, exp_status(1'b1));

      // R5 interrupt level
      host_write(2'd2, 8'h10);
      ack_n = 1'b0; wait_cyc(4);
      check("R5 irq ack low", {7'h0, irq}, 8'h01);
      ack_n = 1'b1; wait_cyc(4);
      check("R5 irq ack high", {7'h0, irq}, 8'h00);
      ack_n = 1'b0; wait_cyc(4);
      host_write(2'd2, 8'h00);
      check("R5 irq enable off", {7'h0, irq}, 8'h00);
      ack_n = 1'b1; wait_cyc(4);

      // R6 status frozen during read strobe
      @(negedge clk);
      addr = 2'd1; rd_n = 1'b0;
      @(negedge clk);
      v1 = rdata;
      check("R6 status before", v1, exp_status(1'b1));
      ack_n = 1'b0; busy = 1'b1;
      wait_cyc(6);
      check("R6 status held", rdata, v1);
      rd_n = 1'b1;
      wait_cyc(2);
      host_read(2'd1, r);
      check("R6 R7 status after", r, exp_status(1'b1));
      ack_n = 1'b1; busy = 1'b0; wait_cyc(4);

      // R4 direction in bidirectional vs standard
      mode = 3'b001;
      host_write(2'd2, 8'h20);
      check("R4 bidir input", {7'h0, pd_oe}, 8'h00);
      mode = 3'b000; wait_cyc(1);
      check("R4 std forces drive", {7'h0, pd_oe}, 8'h01);

      // R10 writes to bits 7:6 ignored
      host_write(2'd2, 8'hC0);
      host_read(2'd2, r);
      check("R10 high bits", r, 8'hC0);

      // random mix
      for (int i = 0; i < 40; i++) begin
         mode  = ($urandom_range(0, 1) == 1) ? 3'b001 : 3'b000;
         flip  = 4'($urandom_range(0, 15));
         err_n = 1'($urandom); sel = 1'($urandom); pe = 1'($urandom);
         ack_n = 1'($urandom); busy = 1'($urandom);
         pd_in = 8'($urandom);
         c     = 6'($urandom);
         host_write(2'd2, {2'($urandom), c});
         r = 8'($urandom);
         host_write(2'd0, r);
         check("R1 data out", pd_out, r);
         host_read(2'd0, r);
         check("R1 data in", r, pd_in);
         host_read(2'd2, r);
         check("R2,R3 ctrl read", r, exp_ctrl(c));
         check("R2,R3 pins", {4'h0, selin_n, init_n, afd_n, stb_n}, {4'h0, exp_pins(c)});
         check("R4 oe", {7'h0, pd_oe}, {7'h0, (mode == 3'b000) | ~c[5]});
         check("R5 irq", {7'h0, irq}, {7'h0, c[4] & ~ack_n});
         host_read(2'd1, r);
         check("R7 status", r, exp_status(1'b1));
      end
      flip = 4'h0;
      busy = 1'b0;
      ack_n = 1'b1;

      // R8 / R9 enhanced timeout
      mode = 3'b100; wait_cyc(4);
      host_read(2'd1, r);
      check("R8 enh idle", r, exp_status(1'b0));
      host_write(2'd0, 8'h5A);
      wait_cyc(20);
      host_read(2'd1, r);
      check("R8 before limit", r, exp_status(1'b0));
      wait_cyc(TO_CYC);
      host_read(2'd1, r);
      check("R8 timed out", r, exp_status(1'b1));
      host_write(2'd1, 8'h00);
      host_read(2'd1, r);
      check("R9 write zero keeps", r, exp_status(1'b1));
      host_write(2'd1, 8'h01);
      host_read(2'd1, r);
      check("R9 write one clears", r, exp_status(1'b0));

      host_write(2'd0, 8'hA5);
      busy = 1'b1;
      wait_cyc(TO_CYC + 16);
      host_read(2'd1, r);
      check("R8 handshake in time", r, exp_status(1'b0));
      busy = 1'b0; wait_cyc(4);

      host_write(2'd0, 8'h11);
      wait_cyc(TO_CYC + 16);
      host_read(2'd1, r);
      check("R8 second timeout", r, exp_status(1'b1));
      mode = 3'b000; wait_cyc(3);
      host_read(2'd1, r);
      check("R8 outside enh reads one", r, exp_status(1'b1));
      mode = 3'b100; wait_cyc(3);
      host_read(2'd1, r);
      check("R9 leave clears", r, exp_status(1'b0));

      done = 1'b1;
      report();
      $finish;
   end
endmodule